// File: doc/BRIEF.md
# Instruction Address Breakpoint Comparator

This block watches the stream of instruction addresses on their way to execution and compares each one with a breakpoint word that software writes. When a valid instruction's word address equals the stored address and the breakpoint is armed, the block kills that instruction in the same cycle, so that it never executes. On the next cycle it raises a precise exception request that carries the exception vector offset.

The breakpoint word holds both the word address and the arm flag. Its upper 30 bits are the word address. Bit 1 (bit 0 is the least significant) is the arm flag. Bit 0 is stored and read back, but it plays no part in matching.

Once a request has been raised, it stays pending until the core acknowledges it. While the request is pending, the block ignores further matches, so a stalled or replayed copy of the same instruction does not trigger a second time.

Top module: `insn_bkpt_unit`

## Requirements
- R1: After reset, `bkpt_rd_data` is 0. From the cycle after a write, it returns all 32 written bits unchanged, including the arm flag (bit 1) and bit 0.
- R2: `fetch_kill` is high in the same cycle as a fetch when three conditions hold: `fetch_valid` is high, bit 1 of the breakpoint word is 1, and `fetch_addr[31:2]` equals bits 31:2 of the breakpoint word.
- R3: Bits 1:0 of `fetch_addr` and bits 1:0 of the breakpoint word do not take part in the compare.
- R4: `fetch_kill` stays low whenever `fetch_valid` is low, even when the address matches.
- R5: `fetch_kill` stays low whenever bit 1 of the breakpoint word is 0.
- R6: In the cycle after a kill, `exc_req` is high and `exc_vector` reads 0x1300. `exc_vector` reads 0 whenever `exc_req` is low.
- R7: While `exc_req` is high, `fetch_kill` stays low for every fetch. `exc_req` remains high until `exc_ack` is sampled high.
- R8: When `exc_ack` is high in a cycle where `exc_req` is high, `exc_req` is low from the next cycle, and a new match can be taken from then on.
- R9: A fetch in the same cycle as a write is compared against the breakpoint word held before that write. The new word takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| bkpt_wr_en | input | 1 | Write strobe for the breakpoint word |
| bkpt_wr_data | input | 32 | Value to store: bits 31:2 are the word address, bit 1 is the arm flag |
| bkpt_rd_data | output | 32 | Current breakpoint word |
| fetch_valid | input | 1 | The instruction address on `fetch_addr` is valid this cycle |
| fetch_addr | input | 32 | Address of the instruction about to execute |
| fetch_kill | output | 1 | Suppresses the instruction that matched |
| exc_req | output | 1 | Breakpoint exception request is pending |
| exc_ack | input | 1 | The core has taken the pending exception |
| exc_vector | output | 32 | Vector offset while a request is pending, otherwise 0 |

## Verification
The assertions check on every cycle the properties that hold regardless of address values. A kill only ever appears with a valid fetch and an armed word, and never while a request is pending. A kill is always followed by a request. A request holds until it is acknowledged and clears right after. A write always reads back on the following cycle. What only the bench's scenarios can show is the address behaviour. That covers which address patterns match, whether the low two bits are really ignored on both sides of the compare, and whether a fetch in the same cycle as a write sees the old word. The bench covers these with directed cases and with random traffic that is biased towards near-matches.

// File: rtl/iabr_pkg.sv
package iabr_pkg;

  // Request tracker states
  typedef enum logic {
    BP_IDLE = 1'b0,
    BP_PEND = 1'b1
  } bp_state_e;

  // Number of equal-width slices needed to cover a compare of cmp_w bits
  function automatic int unsigned slice_count(input int unsigned cmp_w,
                                              input int unsigned slice_w);
    return (cmp_w + slice_w - 1) / slice_w;
  endfunction

endpackage

// File: rtl/bkpt_store.sv
module bkpt_store #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] word_q
);

  logic [WORD_W-1:0] word_r;
  logic [WORD_W-1:0] word_d;

  // Next-state: load on write strobe, otherwise hold
  always_comb begin
    word_d = word_r;
    if (wr_en) begin
      word_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      word_r <= '0;
    end else if (wr_en) begin
      word_r <= word_d;
    end
  end

  assign word_q = word_r;

  // R1: every written bit is returned from the next cycle on
  assert_readback_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_en |=> (word_q == $past(wr_data)));

endmodule

// File: rtl/bkpt_compare.sv
module bkpt_compare #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned IGN_LSB = 2,
  parameter int unsigned ARM_BIT = 1,
  parameter int unsigned SLICE_W = 8
) (
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic [ADDR_W-1:0] bkpt_word,
  output logic              addr_eq,
  output logic              armed
);
  import iabr_pkg::*;

  localparam int unsigned CMP_W   = ADDR_W - IGN_LSB;
  localparam int unsigned NSLICE  = slice_count(CMP_W, SLICE_W);
  localparam int unsigned PAD_W   = NSLICE * SLICE_W;

  logic [PAD_W-1:0]  a_pad;
  logic [PAD_W-1:0]  b_pad;
  logic [NSLICE-1:0] slice_eq;

  // Only the word address takes part; padding bits are equal on both sides
  assign a_pad = PAD_W'(fetch_addr[ADDR_W-1:IGN_LSB]);
  assign b_pad = PAD_W'(bkpt_word[ADDR_W-1:IGN_LSB]);

  // Slice-wise equality, then an AND tree
  for (genvar gi = 0; gi < NSLICE; gi++) begin : g_slice
    assign slice_eq[gi] = (a_pad[gi*SLICE_W +: SLICE_W] == b_pad[gi*SLICE_W +: SLICE_W]);
  end

  assign addr_eq = &slice_eq;
  assign armed   = bkpt_word[ARM_BIT];

  // Low bits are deliberately left out of the compare
  logic unused_low_bits;
  assign unused_low_bits = ^{fetch_addr[IGN_LSB-1:0], bkpt_word[IGN_LSB-1:0]};

endmodule

// File: rtl/bkpt_pending.sv
module bkpt_pending #(
  parameter int unsigned       VEC_W      = 32,
  parameter logic [VEC_W-1:0]  VEC_OFFSET = VEC_W'(32'h1300)
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             hit,
  input  logic             ack,
  output logic             req,
  output logic [VEC_W-1:0] vector
);
  import iabr_pkg::*;

  bp_state_e state_r;
  bp_state_e state_d;

  // Next-state process
  always_comb begin
    state_d = state_r;
    unique case (state_r)
      BP_IDLE: if (hit) state_d = BP_PEND;
      BP_PEND: if (ack) state_d = BP_IDLE;
      default: state_d = BP_IDLE;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_r <= BP_IDLE;
    end else begin
      state_r <= state_d;
    end
  end

  assign req    = (state_r == BP_PEND);
  assign vector = req ? VEC_OFFSET : '0;

  // R6: a hit always leads to a pending request
  assert_hit_raises_req_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    hit |=> req);

  // R7: request holds until acknowledged
  assert_req_holds_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (req && !ack) |=> req);

  // R8: acknowledge clears the request one cycle later
  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (req && ack) |=> !req);

endmodule

// File: rtl/insn_bkpt_unit.sv
module insn_bkpt_unit #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned IGN_LSB    = 2,
  parameter int unsigned ARM_BIT    = 1,
  parameter int unsigned SLICE_W    = 8,
  parameter int unsigned VEC_W      = 32,
  parameter int unsigned VEC_OFFSET = 32'h1300,
  parameter int unsigned RST_SYNC   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bkpt_wr_en,
  input  logic [ADDR_W-1:0] bkpt_wr_data,
  output logic [ADDR_W-1:0] bkpt_rd_data,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_kill,
  output logic              exc_req,
  input  logic              exc_ack,
  output logic [VEC_W-1:0]  exc_vector
);

  localparam logic [VEC_W-1:0] VEC_VAL = VEC_W'(VEC_OFFSET);

  // Reset: asserted asynchronously, released on the clock
  logic [RST_SYNC-1:0] rst_pipe;
  logic                rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[RST_SYNC-2:0], 1'b1};
    end
  end

  assign rst_ni = rst_pipe[RST_SYNC-1];

  logic [ADDR_W-1:0] word_q;
  logic              addr_eq;
  logic              armed;
  logic              hit;

  bkpt_store #(
    .WORD_W (ADDR_W)
  ) i_store (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .wr_en   (bkpt_wr_en),
    .wr_data (bkpt_wr_data),
    .word_q  (word_q)
  );

  bkpt_compare #(
    .ADDR_W  (ADDR_W),
    .IGN_LSB (IGN_LSB),
    .ARM_BIT (ARM_BIT),
    .SLICE_W (SLICE_W)
  ) i_compare (
    .fetch_addr (fetch_addr),
    .bkpt_word  (word_q),
    .addr_eq    (addr_eq),
    .armed      (armed)
  );

  // A match is taken only for a valid fetch with nothing already pending
  assign hit = fetch_valid && armed && addr_eq && !exc_req && rst_ni;

  bkpt_pending #(
    .VEC_W      (VEC_W),
    .VEC_OFFSET (VEC_VAL)
  ) i_pending (
    .clk    (clk),
    .rst_ni (rst_ni),
    .hit    (hit),
    .ack    (exc_ack),
    .req    (exc_req),
    .vector (exc_vector)
  );

  assign bkpt_rd_data = word_q;
  assign fetch_kill   = hit;

  // R4: no kill without a valid fetch
  assert_kill_needs_valid_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    fetch_kill |-> fetch_valid);

  // R5: no kill while disarmed
  assert_kill_needs_arm_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    fetch_kill |-> bkpt_rd_data[ARM_BIT]);

  // R7: no retrigger while a request is pending
  assert_no_retrigger_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    exc_req |-> !fetch_kill);

  // R2: a kill only for an address equal in its word part
  assert_kill_addr_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    fetch_kill |-> (fetch_addr[ADDR_W-1:IGN_LSB] == bkpt_rd_data[ADDR_W-1:IGN_LSB]));

endmodule

// File: tb/test_insn_bkpt_unit.sv
module test_insn_bkpt_unit;

  logic        clk;
  logic        rst_n;
  logic        bkpt_wr_en;
  logic [31:0] bkpt_wr_data;
  logic [31:0] bkpt_rd_data;
  logic        fetch_valid;
  logic [31:0] fetch_addr;
  logic        fetch_kill;
  logic        exc_req;
  logic        exc_ack;
  logic [31:0] exc_vector;

  int unsigned n_tests;
  int unsigned n_fail;
  logic [31:0] reg_m;
  logic        pend_m;

  insn_bkpt_unit i_insn_bkpt_unit (
    .clk          (clk),
    .rst_n        (rst_n),
    .bkpt_wr_en   (bkpt_wr_en),
    .bkpt_wr_data (bkpt_wr_data),
    .bkpt_rd_data (bkpt_rd_data),
    .fetch_valid  (fetch_valid),
    .fetch_addr   (fetch_addr),
    .fetch_kill   (fetch_kill),
    .exc_req      (exc_req),
    .exc_ack      (exc_ack),
    .exc_vector   (exc_vector)
  );

  // 250 MHz
  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic exp_kill(input logic v, input logic [31:0] a,
                                    input logic [31:0] r, input logic p);
    return v && r[1] && (a[31:2] == r[31:2]) && !p;
  endfunction

  function automatic logic [31:0] exp_vec(input logic p);
    return p ? 32'h0000_1300 : 32'h0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check after settling, update model at posedge
  task automatic step(input string tag, input logic wr, input logic [31:0] wd,
                      input logic v, input logic [31:0] a, input logic ack);
    logic k;
    @(negedge clk);
    bkpt_wr_en   = wr;
    bkpt_wr_data = wd;
    fetch_valid  = v;
    fetch_addr   = a;
    exc_ack      = ack;
    #1;
    k = exp_kill(v, a, reg_m, pend_m);
    check({tag, " kill"}, 32'(fetch_kill), 32'(k));
    check("R7 R8 req", 32'(exc_req), 32'(pend_m));
    check("R6 vector", exc_vector, exp_vec(pend_m));
    check("R1 readback", bkpt_rd_data, reg_m);
    @(posedge clk);
    if (k) pend_m = 1'b1;
    else if (pend_m && ack) pend_m = 1'b0;
    if (wr) reg_m = wd;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step("R4", 1'b0, 32'h0, 1'b0, 32'h0, 1'b0);
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    n_tests = 0;
    n_fail  = 0;
    reg_m   = 32'h0;
    pend_m  = 1'b0;
    void'($urandom(32'h1D2B_0A51));
    rst_n        = 1'b0;
    bkpt_wr_en   = 1'b0;
    bkpt_wr_data = 32'h0;
    fetch_valid  = 1'b1;
    fetch_addr   = 32'h0;
    exc_ack      = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1 reset rd", bkpt_rd_data, 32'h0);
    check("R6 reset req", 32'(exc_req), 32'h0);
    check("R5 reset kill", 32'(fetch_kill), 32'h0);
    rst_n = 1'b1;
    fetch_valid = 1'b0;
    repeat (4) @(posedge clk);

    // R1: write and read back, bit 0 kept
    step("R1", 1'b1, 32'h0000_4003, 1'b0, 32'h0, 1'b0);
    idle(1);
    // R2, R3: register bit 0 set, fetch with low bits zero still matches
    step("R3", 1'b0, 32'h0, 1'b1, 32'h0000_4000, 1'b0);
    // R7: pending, same address again, no retrigger
    step("R7", 1'b0, 32'h0, 1'b1, 32'h0000_4000, 1'b0);
    step("R7", 1'b0, 32'h0, 1'b1, 32'h0000_4000, 1'b0);
    // R8: acknowledge, then match available again
    step("R8", 1'b0, 32'h0, 1'b1, 32'h0000_4000, 1'b1);
    step("R8", 1'b0, 32'h0, 1'b1, 32'h0000_4002, 1'b0);
    step("R8", 1'b0, 32'h0, 1'b0, 32'h0, 1'b1);
    // R3: low fetch bits ignored
    step("R3", 1'b0, 32'h0, 1'b1, 32'h0000_4003, 1'b0);
    step("R8", 1'b0, 32'h0, 1'b0, 32'h0, 1'b1);
    // R4: address matches but not valid
    step("R4", 1'b0, 32'h0, 1'b0, 32'h0000_4000, 1'b0);
    // R2: neighbouring word must not match
    step("R2", 1'b0, 32'h0, 1'b1, 32'h0000_4004, 1'b0);
    step("R2", 1'b0, 32'h0, 1'b1, 32'h8000_4000, 1'b0);
    // R5: disarmed word
    step("R5", 1'b1, 32'h0000_4001, 1'b0, 32'h0, 1'b0);
    step("R5", 1'b0, 32'h0, 1'b1, 32'h0000_4000, 1'b0);
    // R9: write and fetch together use the old word
    step("R9", 1'b1, 32'h0000_8002, 1'b1, 32'h0000_8000, 1'b0);
    step("R9", 1'b0, 32'h0, 1'b1, 32'h0000_8000, 1'b0);
    step("R8", 1'b0, 32'h0, 1'b0, 32'h0, 1'b1);
    // R9: rearm and disarm in the same cycle as a matching fetch
    step("R9", 1'b1, 32'h0000_8000, 1'b1, 32'h0000_8000, 1'b0);
    step("R8", 1'b0, 32'h0, 1'b0, 32'h0, 1'b1);
    step("R9", 1'b0, 32'h0, 1'b1, 32'h0000_8000, 1'b0);

    // Random traffic biased towards near-matches
    for (int i = 0; i < 3000; i++) begin
      logic        wr;
      logic [31:0] wd;
      logic        v;
      logic [31:0] a;
      logic        ack;
      wr  = ($urandom % 16) == 0;
      wd  = $urandom;
      if (($urandom % 4) != 0) wd[1] = 1'b1;
      v   = ($urandom % 4) != 0;
      case ($urandom % 4)
        0: a = $urandom;
        1: a = reg_m ^ (32'h1 << ($urandom % 32));
        default: a = {reg_m[31:2], 2'($urandom)};
      endcase
      ack = ($urandom % 3) == 0;
      step("R2", wr, wd, v, a, ack);
    end

    finish_run();
  end

endmodule